// File: doc/BRIEF.md
# Gray-Coded Time Tag Clock-Domain Crossing

This block moves a slowly advancing time tag from a source clock domain into a destination clock domain that has no fixed relation to it. The destination clock may run far faster or far slower than the tag rate, so nothing in the design depends on which of the two clocks is faster.

In the source domain, a binary counter advances by one on each tick. With the intended 1 kHz tick, one count equals one millisecond. Every source clock cycle, the counter is turned into Gray code and registered. Only that registered Gray word crosses the boundary. Because consecutive counts differ in a single Gray bit, a sample taken at any instant gives either the old count or the new one, never a mixture of bits.

In the destination domain, each Gray bit passes through a flop synchroniser. A capture strobe freezes the synchronised word. A pipeline then rebuilds the binary value segment by segment, starting from the most significant bits. When it finishes, it presents the result with a one-cycle valid pulse.

Top module: `gray_tag_xfer`

## Requirements
- R1: After both resets, `dst_tag` is 0 and `dst_tag_valid` is 0. The source counter starts at 0, so a capture taken with no ticks returns 0.
- R2: The source counter adds exactly one for each source cycle in which `src_tick` is sampled high, and holds its value otherwise.
- R3: The registered Gray word that crosses the boundary changes in at most one bit per source clock cycle. The code is g[i] = b[i] ^ b[i+1], with the top bit equal to the top binary bit.
- R4: If `dst_capture` is sampled high at destination edge n, then `dst_tag_valid` is high for the cycle that follows edge n+TAG_W/SEG_W (edge n+4 by default). Captures on consecutive cycles give valid pulses on consecutive cycles.
- R5: If no tick has occurred for a settling time before the capture, the decoded `dst_tag` equals the source count exactly. The settling time is one source cycle plus SYNC_STAGES destination cycles.
- R6: While ticks are arriving, the decoded value equals either the count at the capture edge or that count minus one.
- R7: `dst_tag` changes only in a cycle where `dst_tag_valid` is high, and otherwise holds the last decoded value.
- R8: Results are correct when the destination clock is faster than the source clock and when it is slower.
- R9: The counter wraps from all ones to zero, and a capture after the wrap decodes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source-domain clock that also carries the tick |
| src_rst_n | input | 1 | Active-low reset, source domain |
| src_tick | input | 1 | Advance the time tag by one (sampled each source cycle) |
| dst_clk | input | 1 | Destination-domain clock, any rate |
| dst_rst_n | input | 1 | Active-low reset, destination domain |
| dst_capture | input | 1 | Take a snapshot of the synchronised tag |
| dst_tag | output | TAG_W | Last decoded binary time tag |
| dst_tag_valid | output | 1 | One-cycle pulse when a new decoded tag appears |

## Verification
Captures are taken in four situations, each with a different purpose:
- After long quiet spells in the source. These must match the count exactly, which isolates counting and decoding errors from crossing uncertainty.
- While ticks arrive steadily. The one-count tolerance applies here and exposes any sample that mixes bits from two counts.
- Back to back on consecutive cycles. This separates a correct pipeline from one that drops or merges tokens.
- With the destination clock slowed below the source clock.

A narrow instance is also counted through its all-ones value to show that the wrap decodes to zero.

// File: rtl/tagx_pkg.sv
package tagx_pkg;
    // default geometry of the time tag crossing
    localparam int unsigned TAGX_TAG_W  = 32;
    localparam int unsigned TAGX_SEG_W  = 8;
    localparam int unsigned TAGX_SYNC_N = 2;
endpackage

// File: rtl/tagx_src.sv
module tagx_src #(
    parameter int unsigned TAG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [TAG_W-1:0] gray_o
);
    typedef struct packed {
        logic [TAG_W-1:0] cnt;
        logic [TAG_W-1:0] gry;
    } src_st_t;

    src_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (tick_i) begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
        // registered Gray copy of the current binary count
        nxt_d.gry = cur_q.cnt ^ (cur_q.cnt >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign gray_o = cur_q.gry;

    // R2: the count only ever moves by a single step
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.cnt != $past(cur_q.cnt)) |-> (cur_q.cnt == TAG_W'($past(cur_q.cnt) + 1'b1)));

    // R3: at most one bit of the crossing word flips per source cycle
    p_gray_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cur_q.gry ^ $past(cur_q.gry)) <= 1);
endmodule

// File: rtl/tagx_sync.sv
module tagx_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q, chain_d;

    always_comb begin
        chain_d[0] = din_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout_o = chain_q[STAGES-1];
endmodule

// File: rtl/tagx_decode.sv
module tagx_decode #(
    parameter int unsigned TAG_W = 32,
    parameter int unsigned SEG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [TAG_W-1:0] gray_i,
    output logic [TAG_W-1:0] tag_o,
    output logic             tag_valid_o
);
    localparam int unsigned NSEG = TAG_W / SEG_W;

    typedef struct packed {
        logic             vld;
        logic             par;   // binary bit just above the next segment
        logic [TAG_W-1:0] gry;
        logic [TAG_W-1:0] bin;
    } stg_t;

    // stage 0 is the capture register, stage s has s segments decoded
    stg_t [NSEG:0] cur_q, nxt_d;

    always_comb begin
        logic run;
        run   = 1'b0;
        nxt_d = cur_q;
        nxt_d[0].vld = capture_i;
        if (capture_i) begin
            nxt_d[0].gry = gray_i;
            nxt_d[0].bin = '0;
            nxt_d[0].par = 1'b0;
        end
        for (int s = 1; s <= int'(NSEG); s++) begin
            nxt_d[s].vld = cur_q[s-1].vld;
            if (cur_q[s-1].vld) begin
                run          = cur_q[s-1].par;
                nxt_d[s].gry = cur_q[s-1].gry;
                nxt_d[s].bin = cur_q[s-1].bin;
                for (int j = int'(SEG_W) - 1; j >= 0; j--) begin
                    run = run ^ cur_q[s-1].gry[(int'(NSEG) - s) * int'(SEG_W) + j];
                    nxt_d[s].bin[(int'(NSEG) - s) * int'(SEG_W) + j] = run;
                end
                nxt_d[s].par = run;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign tag_o       = cur_q[NSEG].bin;
    assign tag_valid_o = cur_q[NSEG].vld;

    // R7: the presented tag moves only together with a valid pulse
    p_tag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_valid_o |-> $stable(tag_o));
endmodule

// File: rtl/gray_tag_xfer.sv
module gray_tag_xfer #(
    parameter int unsigned TAG_W       = tagx_pkg::TAGX_TAG_W,
    parameter int unsigned SEG_W       = tagx_pkg::TAGX_SEG_W,
    parameter int unsigned SYNC_STAGES = tagx_pkg::TAGX_SYNC_N
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic             src_tick,
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    input  logic             dst_capture,
    output logic [TAG_W-1:0] dst_tag,
    output logic             dst_tag_valid
);
    localparam int unsigned NSEG  = TAG_W / SEG_W;
    localparam int unsigned LAT   = NSEG + 1;
    localparam int unsigned LAT_W = $clog2(LAT + 1);

    logic [TAG_W-1:0] gray_src;
    logic [TAG_W-1:0] gray_dst;

    tagx_src #(.TAG_W(TAG_W)) u_src (
        .clk    (src_clk),
        .rst_n  (src_rst_n),
        .tick_i (src_tick),
        .gray_o (gray_src)
    );

    tagx_sync #(.WIDTH(TAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (dst_clk),
        .rst_n  (dst_rst_n),
        .din_i  (gray_src),
        .dout_o (gray_dst)
    );

    tagx_decode #(.TAG_W(TAG_W), .SEG_W(SEG_W)) u_dec (
        .clk         (dst_clk),
        .rst_n       (dst_rst_n),
        .capture_i   (dst_capture),
        .gray_i      (gray_dst),
        .tag_o       (dst_tag),
        .tag_valid_o (dst_tag_valid)
    );

    // cycles since destination reset, saturating; gates the latency check
    logic [LAT_W-1:0] since_q, since_d;
    always_comb begin
        since_d = since_q;
        if (since_q != LAT_W'(LAT)) begin
            since_d = since_q + 1'b1;
        end
    end
    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            since_q <= '0;
        end else begin
            since_q <= since_d;
        end
    end

    // R4: each capture yields exactly one valid pulse, NSEG cycles after the capture edge
    p_valid_latency_r4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (since_q == LAT_W'(LAT)) |-> (dst_tag_valid == $past(dst_capture, LAT)));
endmodule

// File: tb/tb_gray_tag_xfer.sv
module tb_gray_tag_xfer;
    logic        src_clk = 1'b0, dst_clk = 1'b0;
    logic        src_rst_n = 1'b0, dst_rst_n = 1'b0;
    logic        src_tick = 1'b0, w_tick = 1'b0, dst_capture = 1'b0;
    logic [31:0] dst_tag;
    logic        dst_tag_valid;
    logic [7:0]  w_tag;
    logic        w_valid;

    int tests = 0, fails = 0;
    int dst_half = 7;
    bit running = 1'b0;

    always #10 src_clk = ~src_clk;                 // 50 MHz
    always begin #(dst_half) dst_clk = ~dst_clk; end

    gray_tag_xfer dut (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_tick(src_tick),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_capture(dst_capture),
        .dst_tag(dst_tag), .dst_tag_valid(dst_tag_valid)
    );

    gray_tag_xfer #(.TAG_W(8), .SEG_W(2), .SYNC_STAGES(2)) dut_w (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_tick(w_tick),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_capture(dst_capture),
        .dst_tag(w_tag), .dst_tag_valid(w_valid)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural model of the source count
    int unsigned model_cnt = 0;
    int quiet = 0;
    always @(posedge src_clk) begin
        if (!src_rst_n) begin
            model_cnt = 0; quiet = 0;
        end else if (src_tick) begin
            model_cnt = model_cnt + 1; quiet = 0;
        end else if (quiet < 100000) begin
            quiet = quiet + 1;
        end
    end

    // expected destination behaviour
    int unsigned exp_q[$];
    bit          tol_q[$];
    logic [4:0]  hist = '0;
    logic [31:0] last_tag = '0;
    always @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            hist <= '0;
        end else begin
            hist <= {hist[3:0], dst_capture};
            if (dst_capture) begin
                exp_q.push_back(model_cnt);
                tol_q.push_back(quiet < 16);
            end
        end
    end

    always @(negedge dst_clk) begin
        if (running) begin
            chk(dst_tag_valid == hist[4], "R4 valid timing", dst_tag_valid, hist[4]);
            if (hist[4] && exp_q.size() > 0) begin
                int unsigned e;
                bit t, ok;
                e = exp_q.pop_front();
                t = tol_q.pop_front();
                ok = (dst_tag == e) || (t && dst_tag == e - 1);
                chk(ok, t ? "R6 tag while ticking" : "R5/R2 tag exact", dst_tag, e);
                last_tag = dst_tag;
            end else if (!hist[4]) begin
                chk(dst_tag == last_tag, "R7 tag hold", dst_tag, last_tag);
            end
        end
    end

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge src_clk) src_tick = 1'b1;
            @(negedge src_clk) src_tick = 1'b0;
            repeat (gap) @(negedge src_clk);
        end
    endtask

    task automatic cap_once();
        @(negedge dst_clk) dst_capture = 1'b1;
        @(negedge dst_clk) dst_capture = 1'b0;
    endtask

    task automatic drain();
        repeat (8) @(negedge dst_clk);
    endtask

    initial begin
        repeat (200000) @(posedge src_clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge src_clk);
        // R1: reset state
        chk(dst_tag == 0, "R1 tag after reset", dst_tag, 0);
        chk(dst_tag_valid == 0, "R1 valid after reset", dst_tag_valid, 0);
        src_rst_n = 1'b1; dst_rst_n = 1'b1;
        @(negedge dst_clk);
        running = 1'b1;
        repeat (3) @(negedge src_clk);

        // R1: capture with no ticks gives 0
        cap_once(); drain();
        chk(dst_tag == 0, "R1 first capture", dst_tag, 0);

        // R2/R5: counted ticks, then quiet capture
        ticks(37, 2);
        repeat (40) @(negedge src_clk);
        cap_once(); drain();
        chk(dst_tag == 37, "R2 count after 37 ticks", dst_tag, 37);

        // R6: captures while ticks keep arriving
        fork
            ticks(60, 19);
            for (int k = 0; k < 40; k++) begin
                cap_once();
                repeat (2) @(negedge dst_clk);
            end
        join
        repeat (40) @(negedge src_clk);
        drain();

        // R4: back-to-back captures with a quiet source
        @(negedge dst_clk) dst_capture = 1'b1;
        repeat (6) @(negedge dst_clk);
        dst_capture = 1'b0;
        drain();
        chk(dst_tag == 97, "R4 back-to-back value", dst_tag, 97);

        // R9: wrap of the narrow instance
        for (int i = 0; i < 255; i++) begin
            @(negedge src_clk) w_tick = 1'b1;
            @(negedge src_clk) w_tick = 1'b0;
        end
        repeat (40) @(negedge src_clk);
        cap_once();
        repeat (4) @(negedge dst_clk);
        chk(w_valid == 1'b1 && w_tag == 8'd255, "R9 all-ones before wrap", w_tag, 255);
        @(negedge src_clk) w_tick = 1'b1;
        @(negedge src_clk) w_tick = 1'b0;
        repeat (40) @(negedge src_clk);
        cap_once();
        repeat (4) @(negedge dst_clk);
        chk(w_valid == 1'b1 && w_tag == 8'd0, "R9 wrap to zero", w_tag, 0);
        drain();

        // R8: destination slower than source
        dst_half = 37;
        repeat (4) @(negedge dst_clk);
        for (int k = 0; k < 5; k++) begin
            ticks(k + 3, 3);
            repeat (60) @(negedge src_clk);
            cap_once();
        end
        drain();
        chk(dst_tag == 97 + 25, "R8 slow destination", dst_tag, 122);

        chk(exp_q.size() == 0, "R4 every capture answered", exp_q.size(), 0);
        running = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule